// File: doc/BRIEF.md
# Compare-Based PWM Generator

This block produces a fixed-frequency pulse-width modulated signal for chopping the active switches of a motor inverter bridge. A free-running counter climbs from zero to a programmed period limit and then returns to zero. The clock edge on which the counter matches the limit starts a new period and sets the output flip-flop. A second equality match, against the programmed duty value, clears the flip-flop. A period limit of N gives a period of N+1 clocks, so at a 50 MHz clock a limit of 2499 yields a 20 kHz rate.

The period and duty inputs are copied into shadow registers only at the period boundary. Software or a control loop can therefore change them at any time without corrupting the period in progress. Two duty settings cannot produce a normal pulse, and each is resolved so the output never glitches: a duty of zero holds the output low, and a duty at or above the period limit holds it high. A one-cycle strobe marks the first clock of every period. Downstream logic can use it to align control updates or commutation changes with the pulse train.

Top module: `chop_pwm`

## Requirements
- R1: While the synchronous active-high reset is asserted, the PWM output and the period strobe are both low, whatever the period and duty inputs do.
- R2: With a latched period limit P, every period lasts exactly P+1 clock cycles. A limit of 2499 gives 2500-cycle periods, and a limit of 0 gives 1-cycle periods.
- R3: With a latched duty D where 0 < D < P, the output is high for exactly the first D cycles of each period, counted from the cycle after the wrap edge, and low for the remaining P+1-D cycles.
- R4: With a latched duty of 0, the output stays low for the whole period.
- R5: With a latched duty D that is nonzero and D >= P, the output stays high for the whole period with no low cycle.
- R6: The period strobe is high for exactly one cycle, the first cycle of each period, which is the same cycle in which the output rises for a nonzero duty.
- R7: The period and duty inputs are sampled only on the wrap edge. A change between wraps has no effect on the period in progress.
- R8: The first clock edge after reset is released is a wrap edge. The first period therefore begins in the next cycle, using the inputs present on that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| period_in | input | 16 | Period limit; one period is this value plus one clocks |
| duty_in | input | 16 | Output high time in clocks |
| pwm_out | output | 1 | Registered PWM output |
| period_start | output | 1 | One-cycle strobe in the first cycle of each period |

## Verification
The bench targets the duty edges: 0, 1, P-1, exactly P, and above P. It also drives a period limit of 0, where every cycle is a wrap. A design that cleared on the duty match without the one-cycle lead would produce pulses one clock too long. A design without saturation would produce a one-cycle low notch when the duty equals the period limit. The bench changes the inputs in the middle of a period and checks that the period in progress keeps its old shape; a design without shadow registers would bend that period. It also checks that the first period after reset starts on the very first edge and that the 2499 limit gives a 2500-cycle period.

// File: rtl/chop_pwm_pkg.sv
`timescale 1ns/1ps
package chop_pwm_pkg;
  // How the output flip-flop behaves across one period
  typedef enum logic [1:0] {
    DUTY_ZERO = 2'd0,   // held low
    DUTY_PART = 2'd1,   // set at wrap, cleared on duty match
    DUTY_FULL = 2'd2    // held high
  } duty_mode_e;
endpackage

// File: rtl/chop_pwm_counter.sv
`timescale 1ns/1ps
module chop_pwm_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  // Period-match comparator
  assign wrap = (cnt == limit);

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (wrap) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/chop_pwm_shadow.sv
`timescale 1ns/1ps
module chop_pwm_shadow
  import chop_pwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] period_in,
  input  logic [CNT_W-1:0] duty_in,
  output logic [CNT_W-1:0] per_q,
  output logic [CNT_W-1:0] duty_q,
  output duty_mode_e       mode_q,
  output duty_mode_e       mode_nxt
);
  // Classify the incoming pair once, so the clear path sees a flag only
  always_comb begin
    if (duty_in == '0)             mode_nxt = DUTY_ZERO;
    else if (duty_in >= period_in) mode_nxt = DUTY_FULL;
    else                           mode_nxt = DUTY_PART;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      per_q  <= '0;
      duty_q <= '0;
      mode_q <= DUTY_ZERO;
    end else if (load) begin
      per_q  <= period_in;
      duty_q <= duty_in;
      mode_q <= mode_nxt;
    end
  end
endmodule

// File: rtl/chop_pwm_latch.sv
`timescale 1ns/1ps
module chop_pwm_latch
  import chop_pwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wrap,
  input  duty_mode_e       mode_nxt,
  input  duty_mode_e       mode_q,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] duty_q,
  output logic             pwm_q,
  output logic             stb_q
);
  localparam int EXT_W = CNT_W + 1;

  logic [EXT_W-1:0] cnt_ahead;
  logic             clr_hit;

  // Duty comparator looks one count ahead so the high time is exactly D
  assign cnt_ahead = {1'b0, cnt} + EXT_W'(1);
  assign clr_hit   = (mode_q == DUTY_PART) && (cnt_ahead == {1'b0, duty_q});

  always_ff @(posedge clk) begin
    if (rst) begin
      pwm_q <= 1'b0;
      stb_q <= 1'b0;
    end else begin
      stb_q <= wrap;
      if (wrap)         pwm_q <= (mode_nxt != DUTY_ZERO);
      else if (clr_hit) pwm_q <= 1'b0;
    end
  end
endmodule

// File: rtl/chop_pwm.sv
`timescale 1ns/1ps
module chop_pwm
  import chop_pwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] period_in,
  input  logic [CNT_W-1:0] duty_in,
  output logic             pwm_out,
  output logic             period_start
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] per_q;
  logic [CNT_W-1:0] duty_q;
  logic             wrap;
  duty_mode_e       mode_q;
  duty_mode_e       mode_nxt;

  chop_pwm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .limit (per_q),
    .cnt   (cnt),
    .wrap  (wrap)
  );

  chop_pwm_shadow #(.CNT_W(CNT_W)) u_shd (
    .clk       (clk),
    .rst       (rst),
    .load      (wrap),
    .period_in (period_in),
    .duty_in   (duty_in),
    .per_q     (per_q),
    .duty_q    (duty_q),
    .mode_q    (mode_q),
    .mode_nxt  (mode_nxt)
  );

  chop_pwm_latch #(.CNT_W(CNT_W)) u_out (
    .clk      (clk),
    .rst      (rst),
    .wrap     (wrap),
    .mode_nxt (mode_nxt),
    .mode_q   (mode_q),
    .cnt      (cnt),
    .duty_q   (duty_q),
    .pwm_q    (pwm_out),
    .stb_q    (period_start)
  );
endmodule

// File: rtl/chop_pwm_chk.sv
`timescale 1ns/1ps
module chop_pwm_chk
  import chop_pwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             pwm_out,
  input logic             period_start,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] per_q,
  input logic [CNT_W-1:0] duty_q,
  input duty_mode_e       mode_q
);
  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (rst)
    cnt <= per_q);

  assert_part_high_R3: assert property (@(posedge clk) disable iff (rst)
    (mode_q == DUTY_PART && cnt < duty_q) |-> pwm_out);

  assert_part_low_R3: assert property (@(posedge clk) disable iff (rst)
    (mode_q == DUTY_PART && cnt >= duty_q) |-> !pwm_out);

  assert_zero_low_R4: assert property (@(posedge clk) disable iff (rst)
    (mode_q == DUTY_ZERO) |-> !pwm_out);

  assert_full_high_R5: assert property (@(posedge clk) disable iff (rst)
    (mode_q == DUTY_FULL) |-> pwm_out);

  assert_strobe_at_zero_R6: assert property (@(posedge clk) disable iff (rst)
    period_start |-> (cnt == '0));

  assert_strobe_single_R6: assert property (@(posedge clk) disable iff (rst)
    (period_start && per_q != '0) |=> !period_start);

  assert_shadow_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !period_start |-> ($stable(per_q) && $stable(duty_q)));
endmodule

bind chop_pwm chop_pwm_chk #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .pwm_out      (pwm_out),
  .period_start (period_start),
  .cnt          (cnt),
  .per_q        (per_q),
  .duty_q       (duty_q),
  .mode_q       (mode_q)
);

// File: tb/sim_chop_pwm.sv
`timescale 1ns/1ps
module sim_chop_pwm;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  typedef struct {
    bit    pwm;
    bit    stb;
    string req;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] period_in = '0;
  logic [W-1:0] duty_in = '0;
  logic         pwm_out;
  logic         period_start;

  exp_t q[$];
  int   last_len = 0;
  int   n_tests = 0;
  int   n_fail = 0;
  bit   mon_on = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  chop_pwm #(.CNT_W(W)) u0 (
    .clk          (clk),
    .rst          (rst),
    .period_in    (period_in),
    .duty_in      (duty_in),
    .pwm_out      (pwm_out),
    .period_start (period_start)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // Driver: wait until only the final queued period remains, then present the
  // new values mid-period (R7: they must not touch that period) and queue them
  task automatic play(input int p, input int d, input int reps, input string req);
    while (q.size() > last_len) begin
      @(posedge clk); #1;
    end
    period_in = W'(p);
    duty_in   = W'(d);
    for (int r = 0; r < reps; r++) begin
      for (int k = 0; k <= p; k++) begin
        exp_t e;
        e.stb = (k == 0);
        if (d == 0)      e.pwm = 1'b0;
        else if (d >= p) e.pwm = 1'b1;
        else             e.pwm = (k < d);
        e.req = req;
        q.push_back(e);
      end
    end
    last_len = p + 1;
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (mon_on && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check(e.req, "pwm_out", int'(pwm_out), int'(e.pwm));
      check("R6", "period_start", int'(period_start), int'(e.stb));
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R2 watchdog: actual hung expected finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    // R1: outputs low throughout reset, even with live inputs
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "pwm_out in reset", int'(pwm_out), 0);
    check("R1", "period_start in reset", int'(period_start), 0);
    period_in = 16'd3;
    duty_in   = 16'd2;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R1", "pwm_out in reset, inputs live", int'(pwm_out), 0);
    check("R1", "period_start in reset, inputs live", int'(period_start), 0);

    // R8: first period starts on the first edge after release
    play(9, 3, 2, "R8");
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk); #1;
    mon_on = 1'b1;

    play(9, 0, 1, "R4");
    play(9, 9, 1, "R5");
    play(5, 12, 1, "R5");
    play(0, 0, 3, "R4");
    play(0, 1, 3, "R5");
    play(4, 1, 2, "R3");
    play(4, 3, 2, "R3");
    play(6, 2, 1, "R3");
    // R7: wiggle the inputs inside this period, restore before the wrap
    while (q.size() > 4) begin
      @(posedge clk); #1;
    end
    period_in = 16'd2;
    duty_in   = 16'd0;
    @(posedge clk); #1;
    period_in = 16'd11;
    duty_in   = 16'd11;
    @(posedge clk); #1;
    period_in = 16'd6;
    duty_in   = 16'd2;
    play(6, 2, 1, "R7");
    // R2: 20 kHz setting, 2500-cycle period
    play(2499, 1250, 1, "R2");
    play(3, 2, 1, "R3");

    while (q.size() > 0) begin
      @(posedge clk); #1;
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule